// File: doc/BRIEF.md
# SerDes link power mode controller

This block holds the power logic of a serializer/deserializer pair in one clock domain. The serializer half has a reset pin and a run pin. It turns them into a four-bit control-line word. That word is all ones while the serializer is held off, and all zeros once it is released and running. The deserializer half reads the control-line word back in, together with its own reset pin. From these it decides whether it is powered down, in standby or active. While active, it captures a parallel data word into a register. The flag, the mode code and the parallel register are the block's results.

Both reset pins pass through a transient filter. A reset pin must be sampled high on `CLK_MHZ * FILTER_US` consecutive clock edges before that side leaves power-down, so brief glitches have no effect. Standby keeps the parallel register as it was. Power-down clears it. The deserializer enables only on an all-zeros word that follows an all-ones word seen after its own reset has completed. A falling edge that arrives while reset is still settling therefore never enables the link. In the normal system the control-line output is wired straight to the control-line input. The input is kept separate so that line faults and skewed patterns can be applied.

Top module: `serdes_link_pm`

## Requirements
- R1: With `des_rst_n` sampled low on an edge, after that edge `des_mode` is 2'b00 (power-down), `des_en` is 0 and `par_q` is all zeros.
- R2: The deserializer leaves power-down only after `des_rst_n` has been sampled high on LIM = CLK_MHZ*FILTER_US consecutive edges. A high pulse lasting fewer edges leaves `des_mode` at 2'b00.
- R3: On the first edge after the filter completes, `des_mode` becomes 2'b01 (standby) whatever the control lines show, and `par_q` reads zero.
- R4: `ctl_out` is 4'b0000 one edge after the serializer reset filter has completed while `ser_rst_n` and `ser_run` are high. Otherwise it is 4'b1111. No other value ever appears.
- R5: Outside power-down, an edge that samples `ctl_in` == 4'b1111 puts `des_mode` at 2'b01 and arms the enable.
- R6: Outside power-down, an edge that samples `ctl_in` == 4'b0000 while armed puts `des_mode` at 2'b10 (active).
- R7: While `des_mode` is 2'b01, `par_q` keeps its value whatever `par_in` does.
- R8: On every edge where `des_mode` was 2'b10 before the edge and reset stays released, `par_q` takes `par_in`.
- R9: An all-zeros control word that has not been preceded by an all-ones word since the deserializer filter completed does not enable the deserializer.
- R10: A control word that is neither all ones nor all zeros leaves `des_mode` unchanged once the deserializer is out of power-down.
- R11: `des_en` is 1 exactly when `des_mode` is 2'b10. The code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both halves |
| ser_rst_n | input | 1 | Serializer reset, low = power-down |
| ser_run | input | 1 | Serializer run request, low = standby |
| des_rst_n | input | 1 | Deserializer reset, low = power-down |
| ctl_out | output | 4 | Control-line word driven by the serializer |
| ctl_in | input | 4 | Control-line word seen by the deserializer |
| par_in | input | DW | Parallel data presented to the deserializer |
| des_en | output | 1 | Deserializer enabled |
| des_mode | output | 2 | 00 power-down, 01 standby, 10 active |
| par_q | output | DW | Registered parallel output |

## Verification
The case that matters most is the deserializer reset falling on the same edge at which the control word drops to all zeros, or at which the filter completes. Power-down must then win over enabling, and the first released edge must give standby and not active. Random stimulus drops and raises both resets at arbitrary points while the run pin toggles and mixed or forced words are injected on the control lines, so these coincidences arise repeatedly. Each cycle, every output is compared with a bench model built from the requirements.

// File: rtl/serdes_link_pm.sv
module serdes_link_pm #(
  parameter int CLK_MHZ   = 200,
  parameter int FILTER_US = 15,
  parameter int DW        = 16
) (
  input  logic          clk,
  input  logic          ser_rst_n,
  input  logic          ser_run,
  input  logic          des_rst_n,
  output logic [3:0]    ctl_out,
  input  logic [3:0]    ctl_in,
  input  logic [DW-1:0] par_in,
  output logic          des_en,
  output logic [1:0]    des_mode,
  output logic [DW-1:0] par_q
);

  localparam int LIM = CLK_MHZ * FILTER_US;
  localparam int CW  = $clog2(LIM + 1);
  localparam logic [1:0] M_PD  = 2'b00;
  localparam logic [1:0] M_SB  = 2'b01;
  localparam logic [1:0] M_ACT = 2'b10;

  logic [CW-1:0] ser_cnt, des_cnt;
  logic          ser_ok, des_ok;
  logic          armed;
  logic          all_hi, all_lo, pd;

  always_ff @(posedge clk) begin
    if (!ser_rst_n) begin
      ser_cnt <= '0;
      ser_ok  <= 1'b0;
    end else begin
      if (ser_cnt != CW'(LIM)) ser_cnt <= ser_cnt + 1'b1;
      if (ser_cnt == CW'(LIM - 1)) ser_ok <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!des_rst_n) begin
      des_cnt <= '0;
      des_ok  <= 1'b0;
    end else begin
      if (des_cnt != CW'(LIM)) des_cnt <= des_cnt + 1'b1;
      if (des_cnt == CW'(LIM - 1)) des_ok <= 1'b1;
    end
  end

  always_ff @(posedge clk)
    ctl_out <= (ser_rst_n && ser_ok && ser_run) ? 4'b0000 : 4'b1111;

  assign all_hi = &ctl_in;
  assign all_lo = ~|ctl_in;
  assign pd     = !des_rst_n || !des_ok;

  always_ff @(posedge clk) begin
    if (pd) begin
      des_mode <= M_PD;
      armed    <= 1'b0;
      par_q    <= '0;
    end else begin
      if (des_mode == M_ACT) par_q <= par_in;
      if (all_hi) begin
        des_mode <= M_SB;
        armed    <= 1'b1;
      end else if (all_lo && armed) begin
        des_mode <= M_ACT;
      end else if (des_mode == M_PD) begin
        des_mode <= M_SB;
      end
    end
  end

  assign des_en = (des_mode == M_ACT);

  // R2: a completed filter implies a saturated high count
  a_r2_filter_full: assert property (@(posedge clk) disable iff (!des_rst_n)
    des_ok |-> (des_cnt == CW'(LIM)));

  // R1: power-down state while the filter has not completed
  a_r1_pd_clear: assert property (@(posedge clk) disable iff (!des_rst_n)
    !des_ok |-> (des_mode == M_PD && par_q == '0));

  // R4: only the two legal control words
  a_r4_ctl_word: assert property (@(posedge clk) disable iff (!ser_rst_n)
    (ctl_out == 4'b0000 || ctl_out == 4'b1111));

  // R7: standby holds the parallel output
  a_r7_hold: assert property (@(posedge clk) disable iff (!des_rst_n)
    (des_mode == M_SB) |=> (par_q == $past(par_q)));

  // R9: no enable without arming
  a_r9_unarmed: assert property (@(posedge clk) disable iff (!des_rst_n)
    (des_mode != M_ACT && !armed && !all_hi) |=> (des_mode != M_ACT));

  // R10: mixed words keep the mode
  a_r10_mixed: assert property (@(posedge clk) disable iff (!des_rst_n)
    (des_ok && des_mode != M_PD && !all_hi && !all_lo) |=> $stable(des_mode));

  // R11: reserved code never used
  a_r11_code: assert property (@(posedge clk) disable iff (!des_rst_n)
    des_mode != 2'b11);

endmodule

// File: tb/test_serdes_link_pm.sv
module test_serdes_link_pm;
  localparam int CLK_MHZ = 200;
  localparam int FILTER_US = 1;
  localparam int DW = 16;
  localparam int LIM = CLK_MHZ * FILTER_US;

  logic clk = 1'b0;
  logic ser_rst_n = 1'b0, ser_run = 1'b0, des_rst_n = 1'b0;
  logic inj = 1'b0;
  logic [3:0] inj_val = 4'h0;
  logic [3:0] ctl_out, ctl_in;
  logic [DW-1:0] par_in = '0;
  logic des_en;
  logic [1:0] des_mode;
  logic [DW-1:0] par_q;

  int n_cmp = 0, n_bad = 0;
  bit live = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign ctl_in = inj ? inj_val : ctl_out;

  serdes_link_pm #(.CLK_MHZ(CLK_MHZ), .FILTER_US(FILTER_US), .DW(DW)) i_serdes_link_pm (
    .clk(clk), .ser_rst_n(ser_rst_n), .ser_run(ser_run), .des_rst_n(des_rst_n),
    .ctl_out(ctl_out), .ctl_in(ctl_in), .par_in(par_in),
    .des_en(des_en), .des_mode(des_mode), .par_q(par_q));

  // requirement-level model
  int m_sc = 0, m_dc = 0;
  bit m_sok = 0, m_dok = 0, m_arm = 0;
  logic [3:0] m_ctl = 4'hF;
  logic [1:0] m_mode = 2'b00;
  logic [DW-1:0] m_par = '0;

  function automatic logic [1:0] next_mode(logic [1:0] cur, logic [3:0] w, bit arm);
    if (w == 4'hF) return 2'b01;
    if (w == 4'h0 && arm) return 2'b10;
    if (cur == 2'b00) return 2'b01;
    return cur;
  endfunction

  always @(posedge clk) begin
    m_sc  <= ser_rst_n ? ((m_sc < LIM) ? m_sc + 1 : m_sc) : 0;
    m_sok <= ser_rst_n && (m_sok || m_sc == LIM - 1);
    m_dc  <= des_rst_n ? ((m_dc < LIM) ? m_dc + 1 : m_dc) : 0;
    m_dok <= des_rst_n && (m_dok || m_dc == LIM - 1);
    m_ctl <= (ser_rst_n && m_sok && ser_run) ? 4'h0 : 4'hF;
    if (!des_rst_n || !m_dok) begin
      m_mode <= 2'b00; m_arm <= 0; m_par <= '0;
    end else begin
      if (m_mode == 2'b10) m_par <= par_in;
      m_mode <= next_mode(m_mode, ctl_in, m_arm);
      if (ctl_in == 4'hF) m_arm <= 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (live && !done) begin
    chk("R4 ctl_out", 32'(ctl_out), 32'(m_ctl));
    chk("R5/R6 des_mode", 32'(des_mode), 32'(m_mode));
    chk("R11 des_en", 32'(des_en), 32'(m_mode == 2'b10));
    chk("R8 par_q", 32'(par_q), 32'(m_par));
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    step(2);
    live = 1'b1;
    step(3);
    chk("R1 reset mode", 32'(des_mode), 32'h0);
    chk("R1 reset en", 32'(des_en), 32'h0);
    chk("R1 reset par", 32'(par_q), 32'h0);
    chk("R4 reset ctl", 32'(ctl_out), 32'hF);

    ser_rst_n = 1; ser_run = 1;
    step(LIM + 3);
    chk("R4 running ctl", 32'(ctl_out), 32'h0);
    chk("R1 des still down", 32'(des_mode), 32'h0);

    des_rst_n = 1;
    step(LIM);
    chk("R2 filter not done", 32'(des_mode), 32'h0);
    step(1);
    chk("R3 first mode", 32'(des_mode), 32'h1);
    chk("R3 cleared par", 32'(par_q), 32'h0);
    step(10);
    chk("R9 stale low no enable", 32'(des_mode), 32'h1);
    chk("R9 en low", 32'(des_en), 32'h0);

    ser_run = 0;
    step(3);
    chk("R4 standby word", 32'(ctl_out), 32'hF);
    chk("R5 standby mode", 32'(des_mode), 32'h1);

    ser_run = 1; par_in = 16'hA5A5;
    step(3);
    chk("R6 active mode", 32'(des_mode), 32'h2);
    chk("R6 en high", 32'(des_en), 32'h1);
    chk("R8 captured", 32'(par_q), 32'hA5A5);

    inj = 1; inj_val = 4'b0110;
    step(5);
    chk("R10 mixed in active", 32'(des_mode), 32'h2);
    inj = 0;

    ser_run = 0;
    step(2);
    par_in = 16'h1234;
    step(4);
    chk("R7 standby hold", 32'(par_q), 32'hA5A5);
    chk("R7 mode", 32'(des_mode), 32'h1);
    inj = 1; inj_val = 4'b1000;
    step(3);
    chk("R10 mixed in standby", 32'(des_mode), 32'h1);
    inj = 0;

    des_rst_n = 0;
    step(2);
    chk("R1 drop mode", 32'(des_mode), 32'h0);
    chk("R1 drop par", 32'(par_q), 32'h0);
    des_rst_n = 1;
    step(LIM - 1);
    des_rst_n = 0;
    step(3);
    chk("R2 short pulse ignored", 32'(des_mode), 32'h0);
    des_rst_n = 1;
    step(LIM + 2);
    chk("R3 after full pulse", 32'(des_mode), 32'h1);

    for (int i = 0; i < 600; i++) begin
      int sel = int'($urandom_range(0, 99));
      par_in = DW'($urandom);
      if (sel < 2) begin
        des_rst_n = 0; step(int'($urandom_range(1, 3))); des_rst_n = 1;
      end else if (sel < 3) begin
        ser_rst_n = 0; step(int'($urandom_range(1, 3))); ser_rst_n = 1;
      end else if (sel < 6) begin
        des_rst_n = 0; step(1); des_rst_n = 1;
        step(int'($urandom_range(1, LIM - 1))); des_rst_n = 0; step(1); des_rst_n = 1;
      end else if (sel < 30) begin
        ser_run = ~ser_run;
      end else if (sel < 45) begin
        inj = 1; inj_val = 4'($urandom);
        step(int'($urandom_range(1, 4)));
        inj = 0;
      end
      step(int'($urandom_range(1, 6)));
    end
    step(4);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule